// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers interrupt conditions into two 16-bit pending banks, A and B. It qualifies each pending bit against a matching 16-bit enable (mask) bank and presents the single most urgent enabled interrupt to a handler as a request line and an encoded cause. Pending bits are sticky. A one-cycle set strobe captures a condition, and the bit stays captured until the handler or the exception logic pulses the matching clear strobe. Software opens or closes classes of interrupt by writing a whole mask bank. While a mask bit is 0, its interrupt waits without being lost.

The controller also has some irregular positions. Two bank-A positions reach the handler whatever their mask bits hold. One bank-A position is not stored at all: it follows a live overflow flag, gated by a trap-enable bit. A second bank-A position belongs to page faults and is never stored. Four exception inputs (instruction failure, page fault, stack overflow, breakpoint) skip the banks and the priority order altogether. They raise a request in the same cycle they appear.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all pending bits and all mask bits are 0, and `irq_req_o`, `irq_cause_o` and `irq_bypass_o` are all 0.
- R2: A 1 on a set strobe bit makes the matching pending bit 1 from the next clock edge. The bit stays 1 with no further strobe until a clear strobe bit removes it at the following edge.
- R3: A pending bit whose mask bit is 0 raises no request. When `mask_we_a_i` or `mask_we_b_i` is high, the whole 16-bit `mask_wdata_i` word replaces that mask bank at the clock edge. The deferred interrupt is then reported from the next cycle.
- R4: Among enabled interrupts, the lowest index wins. Bank A bit i reports cause i, and bank B bit i reports cause 16+i. So bank A bit 0 is the most urgent and bank B bit 15 the least.
- R5: Bank A positions 1 and 4 are enabled whatever their mask bits hold.
- R6: Bank A position 6 is never stored, and set strobes there are ignored. It is enabled in the same cycle whenever `ovf_flag_i` and `ovf_trap_en_i` are both 1, and it ranks at priority 6 like any other position.
- R7: Bank A position 3, the page-fault slot, is never stored. A set strobe there raises no request even when its mask bit is 1.
- R8: Any bypass exception input raises `irq_req_o` and `irq_bypass_o` in the same cycle, overriding all register interrupts. The cause codes are: instruction failure 32, page fault 33, stack overflow 34, breakpoint 35.
- R9: When several bypass inputs are high together, exactly one cause is reported, in the fixed order instruction failure, page fault, stack overflow, breakpoint.
- R10: When a set strobe bit and a clear strobe bit hit the same pending bit in the same cycle, the bit ends up set.
- R11: While `irq_req_o` is 0, `irq_cause_o` is 0 and `irq_bypass_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| set_a_i | input | 16 | Per-bit set strobes, bank A |
| set_b_i | input | 16 | Per-bit set strobes, bank B |
| clr_a_i | input | 16 | Per-bit clear strobes, bank A |
| clr_b_i | input | 16 | Per-bit clear strobes, bank B |
| mask_we_a_i | input | 1 | Write enable for mask bank A |
| mask_we_b_i | input | 1 | Write enable for mask bank B |
| mask_wdata_i | input | 16 | Mask write data |
| ovf_flag_i | input | 1 | Live arithmetic overflow flag |
| ovf_trap_en_i | input | 1 | Overflow trap enable |
| exc_instr_fail_i | input | 1 | Instruction failure exception |
| exc_page_fault_i | input | 1 | Page fault exception |
| exc_stack_ovf_i | input | 1 | Stack overflow exception |
| exc_breakpt_i | input | 1 | Instruction breakpoint exception |
| irq_req_o | output | 1 | Interrupt request |
| irq_cause_o | output | 6 | Encoded cause of the winning interrupt |
| irq_bypass_o | output | 1 | Winning cause is a bypass exception |

## Verification
The bench sets several pending bits across both banks and removes them one at a time. An encoder that scanned from the wrong end, or mapped bank B without the +16 offset, would report the wrong cause. It checks that the overflow position responds in the same cycle and cannot be latched by a strobe, that the page-fault slot stays empty, and that the two mask-exempt positions fire under an all-zero mask. A design that stored these positions or masked them would show a request that should not be there, or miss one that should. It also drives all four bypass inputs at once and then drops them one by one, with a register interrupt waiting underneath, and it strobes set and clear on the same bit together. A wrong bypass order or a clear-wins register would show up as a wrong cause or a missing request.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Ordinal of each bypass exception; also its offset above the register causes.
    typedef enum logic [1:0] {
        BYP_INSTR_FAIL = 2'd0,
        BYP_PAGE_FAULT = 2'd1,
        BYP_STACK_OVF  = 2'd2,
        BYP_BREAKPT    = 2'd3
    } byp_kind_e;

    localparam int NUM_BYPASS = 4;

endpackage

// File: rtl/irq_pend_next.sv
// Next-state logic for one pending bank: sticky bits, set beats clear,
// and positions in NO_STORE are never captured.
module irq_pend_next #(
    parameter int           W        = 16,
    parameter logic [W-1:0] NO_STORE = '0
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] nxt_o
);
    always_comb begin
        nxt_o = ((cur_i & ~clr_i) | set_i) & ~NO_STORE;
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Lowest-index-wins finder over a flat request vector.
module irq_prio_enc #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_bypass_sel.sv
// Fixed-order pick among the exceptions that skip the banks.
module irq_bypass_sel
    import irq_pkg::*;
(
    input  logic      fail_i,
    input  logic      pf_i,
    input  logic      stk_i,
    input  logic      bkpt_i,
    output logic      active_o,
    output byp_kind_e kind_o
);
    always_comb begin
        active_o = fail_i | pf_i | stk_i | bkpt_i;
        if (fail_i)      kind_o = BYP_INSTR_FAIL;
        else if (pf_i)   kind_o = BYP_PAGE_FAULT;
        else if (stk_i)  kind_o = BYP_STACK_OVF;
        else             kind_o = BYP_BREAKPT;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int                BANK_W   = 16,
    parameter int                CAUSE_W  = 6,
    parameter int                OVF_POS  = 6,
    parameter int                PF_POS   = 3,
    parameter logic [BANK_W-1:0] EXEMPT_A = 16'h0012
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [BANK_W-1:0]  set_a_i,
    input  logic [BANK_W-1:0]  set_b_i,
    input  logic [BANK_W-1:0]  clr_a_i,
    input  logic [BANK_W-1:0]  clr_b_i,
    input  logic               mask_we_a_i,
    input  logic               mask_we_b_i,
    input  logic [BANK_W-1:0]  mask_wdata_i,
    input  logic               ovf_flag_i,
    input  logic               ovf_trap_en_i,
    input  logic               exc_instr_fail_i,
    input  logic               exc_page_fault_i,
    input  logic               exc_stack_ovf_i,
    input  logic               exc_breakpt_i,
    output logic               irq_req_o,
    output logic [CAUSE_W-1:0] irq_cause_o,
    output logic               irq_bypass_o
);
    localparam int NUM_BANKS = 2;
    localparam int TOTAL     = NUM_BANKS * BANK_W;
    localparam int IDX_W     = $clog2(TOTAL);
    localparam logic [BANK_W-1:0] NO_STORE_A =
        (BANK_W'(1) << OVF_POS) | (BANK_W'(1) << PF_POS);

    typedef struct packed {
        logic [NUM_BANKS-1:0][BANK_W-1:0] pend;
        logic [NUM_BANKS-1:0][BANK_W-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_BANKS-1:0][BANK_W-1:0] set_v, clr_v, pend_nxt, elig;
    logic [TOTAL-1:0]                 elig_all;
    logic                             enc_found;
    logic [IDX_W-1:0]                 enc_idx;
    logic                             byp_active;
    byp_kind_e                        byp_kind;

    assign set_v = {set_b_i, set_a_i};
    assign clr_v = {clr_b_i, clr_a_i};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] NS = (b == 0) ? NO_STORE_A : '0;
        localparam logic [BANK_W-1:0] EX = (b == 0) ? EXEMPT_A   : '0;

        irq_pend_next #(
            .W        (BANK_W),
            .NO_STORE (NS)
        ) u_pend_next (
            .cur_i (st_q.pend[b]),
            .set_i (set_v[b]),
            .clr_i (clr_v[b]),
            .nxt_o (pend_nxt[b])
        );

        assign elig[b] = st_q.pend[b] & (st_q.mask[b] | EX);
    end

    // Overflow position follows the live flag, never the stored bank.
    assign elig_all = elig | (TOTAL'(ovf_flag_i & ovf_trap_en_i) << OVF_POS);

    irq_prio_enc #(
        .N     (TOTAL),
        .IDX_W (IDX_W)
    ) u_prio_enc (
        .req_i   (elig_all),
        .found_o (enc_found),
        .idx_o   (enc_idx)
    );

    irq_bypass_sel u_bypass_sel (
        .fail_i   (exc_instr_fail_i),
        .pf_i     (exc_page_fault_i),
        .stk_i    (exc_stack_ovf_i),
        .bkpt_i   (exc_breakpt_i),
        .active_o (byp_active),
        .kind_o   (byp_kind)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_nxt;
        if (mask_we_a_i) st_d.mask[0] = mask_wdata_i;
        if (mask_we_b_i) st_d.mask[1] = mask_wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        irq_req_o    = 1'b0;
        irq_bypass_o = 1'b0;
        irq_cause_o  = '0;
        if (byp_active) begin
            irq_req_o    = 1'b1;
            irq_bypass_o = 1'b1;
            irq_cause_o  = CAUSE_W'(TOTAL) + CAUSE_W'(byp_kind);
        end else if (enc_found) begin
            irq_req_o   = 1'b1;
            irq_cause_o = CAUSE_W'(enc_idx);
        end
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int BANK_W  = 16,
    parameter int CAUSE_W = 6,
    parameter int OVF_POS = 6
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [BANK_W-1:0]  set_a_i,
    input logic               ovf_flag_i,
    input logic               ovf_trap_en_i,
    input logic               exc_instr_fail_i,
    input logic               exc_page_fault_i,
    input logic               exc_stack_ovf_i,
    input logic               exc_breakpt_i,
    input logic               irq_req_o,
    input logic [CAUSE_W-1:0] irq_cause_o,
    input logic               irq_bypass_o
);
    localparam int TOTAL = 2 * BANK_W;
    logic any_exc;
    assign any_exc = exc_instr_fail_i | exc_page_fault_i | exc_stack_ovf_i | exc_breakpt_i;

    p_bypass_now_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_exc |-> (irq_req_o && irq_bypass_o));

    p_fail_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_instr_fail_i |-> (irq_cause_o == CAUSE_W'(TOTAL)));

    p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_req_o |-> (irq_cause_o == '0 && !irq_bypass_o));

    p_ovf_live_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_flag_i && ovf_trap_en_i && !any_exc) |->
            (irq_req_o && irq_cause_o <= CAUSE_W'(OVF_POS)));

    p_exempt_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_a_i[1] |=> (irq_req_o && (irq_bypass_o || irq_cause_o <= CAUSE_W'(1))));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .BANK_W  (BANK_W),
    .CAUSE_W (CAUSE_W),
    .OVF_POS (OVF_POS)
) u_chk (.*);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [15:0] set_a_i = '0, set_b_i = '0, clr_a_i = '0, clr_b_i = '0;
    logic        mask_we_a_i = 1'b0, mask_we_b_i = 1'b0;
    logic [15:0] mask_wdata_i = '0;
    logic        ovf_flag_i = 1'b0, ovf_trap_en_i = 1'b0;
    logic        exc_instr_fail_i = 1'b0, exc_page_fault_i = 1'b0;
    logic        exc_stack_ovf_i = 1'b0, exc_breakpt_i = 1'b0;
    logic        irq_req_o;
    logic [5:0]  irq_cause_o;
    logic        irq_bypass_o;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk_i = ~clk_i;

    irq_prio_ctrl i_irq_prio_ctrl (.*);

    task automatic expect_out(input string tag, input logic req, input logic [5:0] cause,
                              input logic byp);
        n_vec++;
        if (irq_req_o !== req || irq_cause_o !== cause || irq_bypass_o !== byp) begin
            n_bad++;
            $display("FAIL %s: req/cause/bypass = %0b/%0d/%0b, expected %0b/%0d/%0b",
                     tag, irq_req_o, irq_cause_o, irq_bypass_o, req, cause, byp);
        end
    endtask

    // Apply strobes for one edge, release them, sample just after the falling edge.
    task automatic strobe(input logic [15:0] sa, input logic [15:0] sb,
                          input logic [15:0] ca, input logic [15:0] cb);
        @(negedge clk_i);
        set_a_i = sa; set_b_i = sb; clr_a_i = ca; clr_b_i = cb;
        @(negedge clk_i);
        set_a_i = '0; set_b_i = '0; clr_a_i = '0; clr_b_i = '0;
        #1;
    endtask

    task automatic wr_mask(input logic bank_b, input logic [15:0] val);
        @(negedge clk_i);
        mask_we_a_i = !bank_b; mask_we_b_i = bank_b; mask_wdata_i = val;
        @(negedge clk_i);
        mask_we_a_i = 1'b0; mask_we_b_i = 1'b0; mask_wdata_i = '0;
        #1;
    endtask

    task automatic live(input logic v, input logic t, input logic [3:0] exc);
        @(negedge clk_i);
        ovf_flag_i = v; ovf_trap_en_i = t;
        {exc_breakpt_i, exc_stack_ovf_i, exc_page_fault_i, exc_instr_fail_i} = exc;
        #1;
    endtask

    task automatic t_reset();
        #1;
        expect_out("R1 reset outputs", 1'b0, 6'd0, 1'b0);
        wr_mask(1'b0, 16'h0000);
        strobe(16'h0004, 16'h0001, '0, '0);
        expect_out("R1 masks clear after reset", 1'b0, 6'd0, 1'b0);
        strobe('0, '0, 16'hFFFF, 16'hFFFF);
    endtask

    task automatic t_sticky();
        wr_mask(1'b0, 16'hFFFF);
        wr_mask(1'b1, 16'hFFFF);
        strobe('0, 16'h0020, '0, '0);
        expect_out("R2 set bank B bit 5", 1'b1, 6'd21, 1'b0);
        @(negedge clk_i); #1;
        expect_out("R2 bit stays set", 1'b1, 6'd21, 1'b0);
        strobe('0, '0, '0, 16'h0020);
        expect_out("R2 clear removes bit", 1'b0, 6'd0, 1'b0);
    endtask

    task automatic t_priority();
        strobe(16'h0400, 16'h0001, '0, '0);
        expect_out("R4 A10 over B0", 1'b1, 6'd10, 1'b0);
        strobe(16'h0100, '0, '0, '0);
        expect_out("R4 A8 wins", 1'b1, 6'd8, 1'b0);
        strobe('0, '0, 16'h0100, '0);
        expect_out("R4 back to A10", 1'b1, 6'd10, 1'b0);
        strobe('0, '0, 16'h0400, '0);
        expect_out("R4 B0 reports 16", 1'b1, 6'd16, 1'b0);
        strobe('0, '0, '0, 16'hFFFF);
        expect_out("R11 idle after clears", 1'b0, 6'd0, 1'b0);
    endtask

    task automatic t_mask_exempt();
        wr_mask(1'b0, 16'h0000);
        strobe(16'h0010, '0, '0, '0);
        expect_out("R5 A4 ignores mask", 1'b1, 6'd4, 1'b0);
        strobe(16'h0002, '0, '0, '0);
        expect_out("R5 A1 ignores mask", 1'b1, 6'd1, 1'b0);
        strobe('0, '0, 16'h0012, '0);
        strobe(16'h0004, '0, '0, '0);
        expect_out("R3 A2 deferred by mask", 1'b0, 6'd0, 1'b0);
        wr_mask(1'b0, 16'h0004);
        expect_out("R3 A2 released by mask write", 1'b1, 6'd2, 1'b0);
        strobe('0, '0, 16'h0004, '0);
    endtask

    task automatic t_overflow();
        wr_mask(1'b0, 16'hFFFF);
        live(1'b1, 1'b0, 4'b0000);
        expect_out("R6 V without T", 1'b0, 6'd0, 1'b0);
        live(1'b1, 1'b1, 4'b0000);
        expect_out("R6 V with T same cycle", 1'b1, 6'd6, 1'b0);
        live(1'b0, 1'b1, 4'b0000);
        expect_out("R6 V drops at once", 1'b0, 6'd0, 1'b0);
        strobe(16'h0040, '0, '0, '0);
        expect_out("R6 strobe at 6 not stored", 1'b0, 6'd0, 1'b0);
        strobe(16'h0080, '0, '0, '0);
        live(1'b1, 1'b1, 4'b0000);
        expect_out("R6 overflow beats A7", 1'b1, 6'd6, 1'b0);
        strobe(16'h0020, '0, '0, '0);
        expect_out("R6 A5 beats overflow", 1'b1, 6'd5, 1'b0);
        live(1'b0, 1'b0, 4'b0000);
        strobe('0, '0, 16'hFFFF, '0);
    endtask

    task automatic t_pf_slot();
        strobe(16'h0008, '0, '0, '0);
        expect_out("R7 page-fault slot never stored", 1'b0, 6'd0, 1'b0);
    endtask

    task automatic t_bypass();
        strobe(16'h0001, '0, '0, '0);
        expect_out("R4 A0 reports 0", 1'b1, 6'd0, 1'b0);
        live(1'b0, 1'b0, 4'b0100);
        expect_out("R8 stack overflow overrides", 1'b1, 6'd34, 1'b1);
        live(1'b0, 1'b0, 4'b0000);
        expect_out("R8 register interrupt returns", 1'b1, 6'd0, 1'b0);
        live(1'b0, 1'b0, 4'b1111);
        expect_out("R9 all four -> fail", 1'b1, 6'd32, 1'b1);
        live(1'b0, 1'b0, 4'b1110);
        expect_out("R9 then page fault", 1'b1, 6'd33, 1'b1);
        live(1'b0, 1'b0, 4'b1100);
        expect_out("R9 then stack", 1'b1, 6'd34, 1'b1);
        live(1'b0, 1'b0, 4'b1000);
        expect_out("R8 breakpoint code", 1'b1, 6'd35, 1'b1);
        live(1'b0, 1'b0, 4'b0000);
        strobe('0, '0, 16'h0001, '0);
        expect_out("R11 idle", 1'b0, 6'd0, 1'b0);
    endtask

    task automatic t_set_wins();
        strobe(16'h0800, '0, 16'h0800, '0);
        expect_out("R10 set beats clear", 1'b1, 6'd11, 1'b0);
        strobe('0, '0, 16'h0800, '0);
        expect_out("R10 later clear works", 1'b0, 6'd0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_sticky();
        t_priority();
        t_mask_exempt();
        t_overflow();
        t_pf_slot();
        t_bypass();
        t_set_wins();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule